// File: doc/BRIEF.md
# Two-Level Segment and Page Address Translator

This block turns a logical address into a physical address by walking two tables that it holds inside. The logical address is read as three fields, from the top down: a segment number, a page number within that segment, and a word offset within that page. The segment number picks an entry of the segment table. That entry gives a base pointer into a shared page table and a length counted in pages. The page number is added to the base, and the sum picks a page-table entry. That entry gives a physical block number, and the block number placed above the unchanged word offset is the physical address.

The page table is reached by addition rather than by joining index bits. Segments of different sizes therefore own runs of different lengths in one page table, and two segments may overlap the same entries. Requests enter through a valid/ready port and results leave through a valid/ready port with a fault flag. A separate write port loads entries of either table. The lookup runs in two registered stages: the segment lookup, then the page lookup. A stall at the output holds both stages.

Top module: `segpage_xlate`

## Requirements
- R1: With default widths the logical address holds the segment in bits [15:12], the page in bits [11:8] and the word in bits [7:0]. A translation that does not fault returns the physical address {block, word}, with the block in bits [15:8] and the word passed through unchanged in bits [7:0].
- R2: The page-table index is the sum of the segment entry's base and the page field. Two segments whose bases differ reach different, possibly overlapping, runs of the same page table.
- R3: A page field greater than or equal to the segment entry's length raises the fault flag. A faulting result always carries a physical address of zero.
- R4: If the sum of base and page does not fit in the page-table index width (6 bits by default, so any sum above 63), the result faults. The index does not wrap.
- R5: Looking up a segment entry or a page-table entry whose valid bit is clear raises the fault flag. After reset every entry of both tables is invalid.
- R6: While res_ready stays high, each accepted request produces its result exactly two cycles after the cycle in which it was accepted. One request can be accepted every cycle.
- R7: While res_valid is high and res_ready is low, the result and fault flag hold steady. Once both stages are full, req_ready drops. No result is lost or reordered.
- R8: A table write does not affect a lookup of the same entry made in the same cycle. A segment write in the cycle a request is accepted, or a page write in the cycle after it, leaves that request with the old entry. Later requests see the new entry.
- R9: In the cycle after reset is asserted, res_valid is low and req_ready is high.
- R10: The write port selects the table with wr_sel (0 = segment table, 1 = page table). A segment entry's data is {valid at bit 11, length at bits [10:6], base at bits [5:0]}. A page entry's data is {valid at bit 8, block at bits [7:0]}. A write whose index or data has nonzero bits above the selected entry's width is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_laddr | input | LA_W (16) | Logical address {segment, page, word} |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | Target table: 0 segment, 1 page |
| wr_idx | input | IDX_W (6) | Entry index |
| wr_data | input | WD_W (12) | Entry contents |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | PA_W (16) | Physical address, zero on fault |
| res_fault | output | 1 | Translation failed |

## Verification
The bench builds the block with its default widths: 16 segments, 16 pages of 256 words, a 64-entry page table and 8-bit blocks. With 4-bit page fields and 6-bit bases, a base near the top of the page table pushes a sum past 63, so index overflow is reachable. Lengths from 0 to 16 cover an empty segment, a full-size segment and the boundary where the page equals the length. Random tables give both overlapping and disjoint page runs for the segments, and random back-pressure fills both stages.

// File: rtl/segpage_pkg.sv
package segpage_pkg;
  typedef enum logic {
    TBL_SEG  = 1'b0,
    TBL_PAGE = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/segpage_seg_stage.sv
module segpage_seg_stage #(
  parameter int SEG_W = 4,
  parameter int PG_W  = 4,
  parameter int WRD_W = 8,
  parameter int PTI_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             in_valid,
  input  logic [SEG_W-1:0] in_seg,
  input  logic [PG_W-1:0]  in_pg,
  input  logic [WRD_W-1:0] in_wrd,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  logic [PG_W:0]    wr_len,
  input  logic [PTI_W-1:0] wr_base,
  output logic             s1_valid,
  output logic             s1_ent_vld,
  output logic [PG_W:0]    s1_len,
  output logic [PTI_W-1:0] s1_base,
  output logic [PG_W-1:0]  s1_pg,
  output logic [WRD_W-1:0] s1_wrd
);
  localparam int DEPTH = 1 << SEG_W;
  localparam int ENT_W = PG_W + 1 + PTI_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;
  logic [DEPTH-1:0] vbits;

  // block-RAM style: write port plus registered read, read returns old data
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_len, wr_base};
    if (ld)    rd_q <= mem[in_seg];
  end

  always_ff @(posedge clk) begin
    if (rst)        vbits <= '0;
    else if (wr_en) vbits[wr_idx] <= wr_vld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_ent_vld <= 1'b0;
    end else if (ld) begin
      s1_valid   <= in_valid;
      s1_ent_vld <= vbits[in_seg];
    end
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      s1_pg  <= in_pg;
      s1_wrd <= in_wrd;
    end
  end

  assign {s1_len, s1_base} = rd_q;
endmodule

// File: rtl/segpage_page_stage.sv
module segpage_page_stage #(
  parameter int PG_W  = 4,
  parameter int WRD_W = 8,
  parameter int PTI_W = 6,
  parameter int BLK_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld,
  input  logic                   s1_valid,
  input  logic                   s1_ent_vld,
  input  logic [PG_W:0]          s1_len,
  input  logic [PTI_W-1:0]       s1_base,
  input  logic [PG_W-1:0]        s1_pg,
  input  logic [WRD_W-1:0]       s1_wrd,
  input  logic                   wr_en,
  input  logic [PTI_W-1:0]       wr_idx,
  input  logic                   wr_vld,
  input  logic [BLK_W-1:0]       wr_blk,
  output logic                   res_valid,
  output logic [BLK_W+WRD_W-1:0] res_paddr,
  output logic                   res_fault
);
  localparam int DEPTH = 1 << PTI_W;

  logic [BLK_W-1:0] mem [DEPTH];
  logic [BLK_W-1:0] blk_q;
  logic [DEPTH-1:0] vbits;
  logic [PTI_W:0]   sum;
  logic             len_bad;
  logic             pre_fault;
  logic             pre_q;
  logic             pte_vld_q;
  logic [WRD_W-1:0] wrd_q;

  // one extra bit keeps the carry so overflow faults instead of wrapping
  assign sum       = {1'b0, s1_base} + (PTI_W+1)'(s1_pg);
  assign len_bad   = ((PG_W+1)'(s1_pg) >= s1_len);
  assign pre_fault = !s1_ent_vld || len_bad || sum[PTI_W];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_blk;
    if (ld)    blk_q <= mem[sum[PTI_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst)        vbits <= '0;
    else if (wr_en) vbits[wr_idx] <= wr_vld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      pre_q     <= 1'b1;
      pte_vld_q <= 1'b0;
    end else if (ld) begin
      res_valid <= s1_valid;
      pre_q     <= pre_fault;
      pte_vld_q <= vbits[sum[PTI_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (ld) wrd_q <= s1_wrd;
  end

  assign res_fault = pre_q || !pte_vld_q;
  assign res_paddr = res_fault ? '0 : {blk_q, wrd_q};
endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate #(
  parameter int SEG_W = 4,
  parameter int PG_W  = 4,
  parameter int WRD_W = 8,
  parameter int PTI_W = 6,
  parameter int BLK_W = 8,
  localparam int LA_W  = SEG_W + PG_W + WRD_W,
  localparam int PA_W  = BLK_W + WRD_W,
  localparam int SE_W  = 1 + (PG_W + 1) + PTI_W,
  localparam int PE_W  = 1 + BLK_W,
  localparam int IDX_W = (SEG_W > PTI_W) ? SEG_W : PTI_W,
  localparam int WD_W  = (SE_W > PE_W) ? SE_W : PE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_laddr,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WD_W-1:0]  wr_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [PA_W-1:0]  res_paddr,
  output logic             res_fault
);
  import segpage_pkg::*;

  logic             s1_adv, s2_adv;
  logic             seg_we, pg_we;
  logic             s1_valid, s1_ent_vld;
  logic [PG_W:0]    s1_len;
  logic [PTI_W-1:0] s1_base;
  logic [PG_W-1:0]  s1_pg;
  logic [WRD_W-1:0] s1_wrd;

  assign s2_adv    = !res_valid || res_ready;
  assign s1_adv    = !s1_valid || s2_adv;
  assign req_ready = s1_adv;

  // writes with stray high bits in index or data are dropped
  assign seg_we = wr_en && (tbl_sel_e'(wr_sel) == TBL_SEG)
                  && ((wr_idx >> SEG_W) == '0) && ((wr_data >> SE_W) == '0);
  assign pg_we  = wr_en && (tbl_sel_e'(wr_sel) == TBL_PAGE)
                  && ((wr_idx >> PTI_W) == '0) && ((wr_data >> PE_W) == '0);

  segpage_seg_stage #(
    .SEG_W(SEG_W), .PG_W(PG_W), .WRD_W(WRD_W), .PTI_W(PTI_W)
  ) u_seg (
    .clk        (clk),
    .rst        (rst),
    .ld         (s1_adv),
    .in_valid   (req_valid),
    .in_seg     (req_laddr[LA_W-1 -: SEG_W]),
    .in_pg      (req_laddr[WRD_W +: PG_W]),
    .in_wrd     (req_laddr[WRD_W-1:0]),
    .wr_en      (seg_we),
    .wr_idx     (wr_idx[SEG_W-1:0]),
    .wr_vld     (wr_data[SE_W-1]),
    .wr_len     (wr_data[PTI_W +: PG_W+1]),
    .wr_base    (wr_data[PTI_W-1:0]),
    .s1_valid   (s1_valid),
    .s1_ent_vld (s1_ent_vld),
    .s1_len     (s1_len),
    .s1_base    (s1_base),
    .s1_pg      (s1_pg),
    .s1_wrd     (s1_wrd)
  );

  segpage_page_stage #(
    .PG_W(PG_W), .WRD_W(WRD_W), .PTI_W(PTI_W), .BLK_W(BLK_W)
  ) u_page (
    .clk        (clk),
    .rst        (rst),
    .ld         (s2_adv),
    .s1_valid   (s1_valid),
    .s1_ent_vld (s1_ent_vld),
    .s1_len     (s1_len),
    .s1_base    (s1_base),
    .s1_pg      (s1_pg),
    .s1_wrd     (s1_wrd),
    .wr_en      (pg_we),
    .wr_idx     (wr_idx[PTI_W-1:0]),
    .wr_vld     (wr_data[BLK_W]),
    .wr_blk     (wr_data[BLK_W-1:0]),
    .res_valid  (res_valid),
    .res_paddr  (res_paddr),
    .res_fault  (res_fault)
  );
endmodule

// File: rtl/segpage_xlate_chk.sv
module segpage_xlate_chk #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            res_valid,
  input logic            res_ready,
  input logic [PA_W-1:0] res_paddr,
  input logic            res_fault
);
  // R3
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_fault |-> res_paddr == '0);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr) && $stable(res_fault));

  // R6
  two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> $past(req_valid && req_ready, 2));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !res_valid && req_ready);
endmodule

bind segpage_xlate segpage_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_paddr (res_paddr),
  .res_fault (res_fault)
);

// File: tb/segpage_xlate_tb.sv
module segpage_xlate_tb;
  localparam int CLK_P = 10;
  localparam int SEG_W = 4, PG_W = 4, WRD_W = 8, PTI_W = 6, BLK_W = 8;
  localparam int LA_W = SEG_W + PG_W + WRD_W;
  localparam int PA_W = BLK_W + WRD_W;
  localparam int IDX_W = 6, WD_W = 12;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready;
  logic [LA_W-1:0] req_laddr = '0;
  logic wr_en = 0, wr_sel = 0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [WD_W-1:0] wr_data = '0;
  logic res_valid, res_ready = 1, res_fault;
  logic [PA_W-1:0] res_paddr;

  int checks = 0, errors = 0, cyc = 0;
  bit lat_mode = 0;
  bit done = 0;
  string cur_tag = "R1";

  logic             m_sv [16];
  logic [PG_W:0]    m_len [16];
  logic [PTI_W-1:0] m_base [16];
  logic             m_pv [64];
  logic [BLK_W-1:0] m_blk [64];

  logic [PA_W:0] exp_q [$];
  int            acc_q [$];

  segpage_xlate u_dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [PA_W:0] xlate(input logic [LA_W-1:0] la);
    logic [SEG_W-1:0] s;
    logic [PG_W-1:0] p;
    logic [PTI_W:0] sm;
    s  = la[15:12];
    p  = la[11:8];
    sm = {1'b0, m_base[s]} + 7'(p);
    if (!m_sv[s] || 5'(p) >= m_len[s] || sm[PTI_W] || !m_pv[sm[5:0]])
      return {1'b1, {PA_W{1'b0}}};
    return {1'b0, m_blk[sm[5:0]], la[7:0]};
  endfunction

  // scoreboard: sampled mid-cycle, values hold until the next rising edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) chk(0, cur_tag, {res_fault, res_paddr}, 0);
        else begin
          logic [PA_W:0] e;
          int a;
          e = exp_q.pop_front();
          a = acc_q.pop_front();
          chk({res_fault, res_paddr} == e, cur_tag, {res_fault, res_paddr}, e);
          if (lat_mode) chk(cyc - a == 2, "R6 latency", cyc - a, 2);
        end
      end
      if (req_valid && req_ready) begin
        exp_q.push_back(xlate(req_laddr));
        acc_q.push_back(cyc);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic model_seg(input int i, input bit v, input int len, input int base);
    m_sv[i] = v; m_len[i] = 5'(len); m_base[i] = 6'(base);
  endtask

  task automatic model_pg(input int i, input bit v, input int blk);
    m_pv[i] = v; m_blk[i] = 8'(blk);
  endtask

  task automatic wr_seg(input int i, input bit v, input int len, input int base);
    wr_en = 1; wr_sel = 0; wr_idx = 6'(i);
    wr_data = {v, 5'(len), 6'(base)};
    tick();
    wr_en = 0;
    model_seg(i, v, len, base);
  endtask

  task automatic wr_pg(input int i, input bit v, input int blk);
    wr_en = 1; wr_sel = 1; wr_idx = 6'(i);
    wr_data = {3'b000, v, 8'(blk)};
    tick();
    wr_en = 0;
    model_pg(i, v, blk);
  endtask

  task automatic send(input logic [LA_W-1:0] la);
    req_valid = 1; req_laddr = la;
    while (1) begin
      @(negedge clk);
      if (req_ready) break;
    end
    tick();
    req_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) tick();
    chk(exp_q.size() == 0, {cur_tag, " drain"}, exp_q.size(), 0);
    tick();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      chk(0, "watchdog", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20240607);
    for (int i = 0; i < 16; i++) model_seg(i, 0, 0, 0);
    for (int i = 0; i < 64; i++) model_pg(i, 0, 0);
    repeat (3) tick();
    @(negedge clk);
    // R9 reset state
    chk(res_valid == 0, "R9 res_valid", res_valid, 0);
    chk(req_ready == 1, "R9 req_ready", req_ready, 1);
    tick();
    rst = 0;
    tick();

    // R5: every entry invalid after reset
    cur_tag = "R5 reset invalid";
    send(16'h0305); drain();

    // R1 / R2 basic walk
    wr_seg(0, 1, 4, 0);
    for (int i = 0; i < 4; i++) wr_pg(i, 1, 8'hA0 + i);
    wr_pg(4, 1, 8'hB4);
    wr_seg(1, 1, 3, 2);
    cur_tag = "R1 field split";
    send(16'h0211); drain();
    chk(xlate(16'h0211) == {1'b0, 16'hA211}, "R1 model", xlate(16'h0211), 17'h0A211);
    cur_tag = "R2 summed index";
    send(16'h1207); send(16'h1033); drain();

    // R3 length bound
    cur_tag = "R3 length";
    send(16'h1307); send(16'h0407); send(16'h0307); drain();

    // R4 overflow
    wr_seg(2, 1, 8, 62);
    wr_pg(62, 1, 8'hC2);
    wr_pg(63, 1, 8'hC3);
    wr_pg(0, 1, 8'hA0);
    cur_tag = "R4 overflow";
    send(16'h2133); send(16'h2233); send(16'h2733); drain();

    // R5 invalid entries
    wr_pg(5, 0, 8'h55);
    wr_seg(3, 1, 4, 4);
    cur_tag = "R5 invalid";
    send(16'h3100); send(16'hF000); send(16'h3000); drain();

    // R10 dropped writes with stray high bits
    wr_en = 1; wr_sel = 1; wr_idx = 6'd4; wr_data = 12'h8_77;
    tick(); wr_en = 0;
    wr_en = 1; wr_sel = 0; wr_idx = 6'd16; wr_data = 12'hFFF;
    tick(); wr_en = 0;
    cur_tag = "R10 dropped write";
    send(16'h3000); send(16'h0000); drain();
    chk(xlate(16'h3000) == {1'b0, 16'hB400}, "R10 model", xlate(16'h3000), 17'h0B400);

    // R8 segment write in the accepting cycle
    cur_tag = "R8 same-cycle seg";
    req_valid = 1; req_laddr = 16'h0001;
    wr_en = 1; wr_sel = 0; wr_idx = 6'd0; wr_data = {1'b1, 5'd4, 6'd4};
    tick();
    req_valid = 0; wr_en = 0;
    model_seg(0, 1, 4, 4);
    drain();
    cur_tag = "R8 later seg";
    send(16'h0001); drain();
    wr_seg(0, 1, 4, 0);

    // R8 page write in the page-lookup cycle
    cur_tag = "R8 same-cycle page";
    req_valid = 1; req_laddr = 16'h0101;
    tick();
    req_valid = 0;
    wr_en = 1; wr_sel = 1; wr_idx = 6'd1; wr_data = {4'b0001, 8'hEE};
    tick();
    wr_en = 0;
    model_pg(1, 1, 8'hEE);
    drain();
    cur_tag = "R8 later page";
    send(16'h0101); drain();

    // R6 back-to-back with fixed latency
    cur_tag = "R6 stream";
    lat_mode = 1;
    req_valid = 1;
    for (int i = 0; i < 6; i++) begin
      req_laddr = {4'(i % 4), 4'(i % 3), 8'(i * 17)};
      tick();
    end
    req_valid = 0;
    drain();
    lat_mode = 0;

    // R7 directed stall
    cur_tag = "R7 stall";
    res_ready = 0;
    send(16'h0222); send(16'h1044);
    req_valid = 1; req_laddr = 16'h2133;
    @(negedge clk);
    chk(req_ready == 0, "R7 req_ready full", req_ready, 0);
    chk(res_valid == 1, "R7 res_valid held", res_valid, 1);
    repeat (3) tick();
    res_ready = 1;
    while (1) begin
      @(negedge clk);
      if (req_ready) break;
    end
    tick();
    req_valid = 0;
    drain();

    // random tables and traffic with back-pressure
    for (int i = 0; i < 16; i++)
      wr_seg(i, ($urandom % 8) != 0, $urandom % 17, $urandom % 64);
    for (int i = 0; i < 64; i++)
      wr_pg(i, ($urandom % 8) != 0, $urandom % 256);
    cur_tag = "R7 random";
    for (int i = 0; i < 3000; i++) begin
      req_valid = ($urandom % 4) != 0;
      req_laddr = 16'($urandom);
      res_ready = ($urandom % 3) != 0;
      tick();
    end
    req_valid = 0;
    res_ready = 1;
    drain();

    done = 1;
    finish_run();
  end
endmodule